// File: doc/BRIEF.md
# Operating Mode Select Register

This block fixes the chip's operating mode from three strap pins while reset is held. It then keeps that mode in one 8-bit register that software can read and rewrite through a simple register port. The straps are a debug-pin strap and two mode-select straps. While reset is asserted, the register loads the image that belongs to the strapped mode on every clock. When reset is released, the image of the last sampled strap value stays in place. The decoded mode, a function code for each of two I/O ports, and two debug flags come from the register and from the reset sample.

After reset, software changes the mode by writing the register. Protection rules guard the change:

- A part that came up in a normal mode may move once, and only to a different normal mode.
- A part in a special mode may change among special modes freely.
- A part in a special mode reaches a normal mode only through two consecutive writes that request it. The first of these writes only arms the change.

A rejected mode change leaves the three mode bits alone, but the four free control bits still take the written data.

Top module: `opmode_ctrl`

## Requirements
- R1: While rst_n is low the register loads from the strap value {debug, hi, lo}: 000→0x19, 001→0x39, 010→0x59, 011→0x79, 100→0x90, 101→0xB0, 110 (reserved)→0x59, 111→0xF0.
- R2: mode_o equals register bits [7:5]. Mode codes: 000 special single-chip, 001 special narrow, 010 special peripheral, 011 special wide, 100 normal single-chip, 101 normal narrow, 111 normal wide. Port function codes: 0 general I/O, 1 address only, 2 multiplexed address/data. In single-chip modes both ports are 0. In narrow modes port A is 2 and port B is 1. Otherwise both ports are 2.
- R3: dbg_enabled_o and dbg_active_o are 1 exactly when the last strap sampled in reset was 000, and they hold until the next reset.
- R4: bus_rdata_o shows the register when bus_addr_i is 0x0B and shows 0 otherwise. Bit 1 always reads 0.
- R5: On a write (bus_wr_i high with bus_addr_i 0x0B), bits 4, 3, 2 and 0 take the data, whatever the mode rules decide.
- R6: In a special mode, a write with data bit 7 = 0 copies data bits 6:5 into the register, any number of times.
- R7: In a special mode, a write with bit 7 = 1 only arms the exit, and the mode bits stay unchanged. The next write with bit 7 = 1 loads bits 7:5 from the data, unless data bits 6:5 are 10, in which case it is rejected and the exit stays armed. A write with bit 7 = 0 disarms, and so does reset.
- R8: In a normal mode, one write selecting a different normal mode (101, 100 or 111) takes effect. Later mode changes are ignored until reset. A write that selects the current mode does not use up the change.
- R9: In a normal mode, writes with bit 7 = 0 or with mode bits 110 leave bits 7:5 unchanged. Mode code 110 never appears in the register.
- R10: With bus_wr_i low, or with bus_addr_i other than 0x0B, the register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are sampled while it is low |
| strap_i | input | 3 | {debug strap, mode hi strap, mode lo strap} |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read-back data |
| mode_o | output | 3 | Current mode code |
| port_a_fn_o | output | 2 | Port A function code |
| port_b_fn_o | output | 2 | Port B function code |
| dbg_enabled_o | output | 1 | Debug enabled at reset |
| dbg_active_o | output | 1 | Debug active at reset |

## Verification
A single write can be rejected by the mode rules while it still updates the free control bits. The rejection can be an unarmed exit request, a second normal switch, or a request for a special or reserved code. Random writes set every data bit independently, so most of these writes carry both effects at once. The bench judges both halves after each write from its own reference state, which holds the register image, the arm flag and the used-change flag. Directed writes pin down the cases where an exit is armed and then cancelled, and where a normal switch has already been spent.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  localparam int REG_W = 8;
  // control bits that every write updates
  localparam logic [REG_W-1:0] FREE_MASK = 8'h1D;

  typedef enum logic [1:0] {
    PF_GPIO = 2'd0,
    PF_ADDR = 2'd1,
    PF_MUX  = 2'd2
  } portfn_e;

  // reserved strap pattern is treated as the special peripheral mode
  function automatic logic [2:0] fold_reserved(input logic [2:0] code);
    return (code == 3'b110) ? 3'b010 : code;
  endfunction

  // register image loaded during reset for a given strap
  function automatic logic [REG_W-1:0] reset_image(input logic [2:0] strap);
    logic [2:0] m;
    logic       spc;
    m   = fold_reserved(strap);
    spc = ~m[2];
    return {m, 1'b1, spc, 1'b0, 1'b0, spc};
  endfunction

  // function code of port p (0 = A, 1 = B) in mode m
  function automatic logic [1:0] port_fn(input logic [2:0] m, input int unsigned p);
    case (m[1:0])
      2'b00:   return PF_GPIO;
      2'b01:   return (p == 0) ? PF_MUX : PF_ADDR;
      default: return PF_MUX;
    endcase
  endfunction

endpackage

// File: rtl/opmode_strap_decode.sv
module opmode_strap_decode
  import opmode_pkg::*;
(
  input  logic [2:0]       strap_i,
  output logic [REG_W-1:0] image_o,
  output logic             dbg_en_o,
  output logic             dbg_act_o
);

  logic single_special;

  assign image_o        = reset_image(strap_i);
  assign single_special = (strap_i == 3'b000);
  assign dbg_en_o       = single_special;
  assign dbg_act_o      = single_special;

endmodule

// File: rtl/opmode_write_guard.sv
module opmode_write_guard
  import opmode_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  logic             armed_i,
  input  logic             once_i,
  input  logic             wr_hit_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] nxt_o,
  output logic             nxt_armed_o,
  output logic             nxt_once_o,
  output logic             ev_arm_o,
  output logic             ev_exit_special_o,
  output logic             ev_normal_switch_o,
  output logic             ev_reject_o
);

  logic [2:0] req;
  logic       in_normal;
  logic       req_normal;
  logic       req_reserved;

  assign req          = wdata_i[7:5];
  assign in_normal    = cur_i[7];
  assign req_normal   = req[2];
  assign req_reserved = (req == 3'b110);

  always_comb begin
    nxt_o              = cur_i;
    nxt_armed_o        = armed_i;
    nxt_once_o         = once_i;
    ev_arm_o           = 1'b0;
    ev_exit_special_o  = 1'b0;
    ev_normal_switch_o = 1'b0;
    ev_reject_o        = 1'b0;
    if (wr_hit_i) begin
      nxt_o = (cur_i & ~FREE_MASK) | (wdata_i & FREE_MASK);
      if (!in_normal) begin
        if (!req_normal) begin
          nxt_o[6:5]  = req[1:0];
          nxt_armed_o = 1'b0;
        end else if (!armed_i) begin
          nxt_armed_o = 1'b1;
          ev_arm_o    = 1'b1;
        end else if (req_reserved) begin
          ev_reject_o = 1'b1;
        end else begin
          nxt_o[7:5]        = req;
          nxt_armed_o       = 1'b0;
          ev_exit_special_o = 1'b1;
        end
      end else begin
        if (!req_normal || req_reserved) begin
          ev_reject_o = 1'b1;
        end else if (req[1:0] != cur_i[6:5]) begin
          if (once_i) begin
            ev_reject_o = 1'b1;
          end else begin
            nxt_o[6:5]         = req[1:0];
            nxt_once_o         = 1'b1;
            ev_normal_switch_o = 1'b1;
          end
        end
      end
      nxt_o[1] = 1'b0;
    end
  end

endmodule

// File: rtl/opmode_port_map.sv
module opmode_port_map
  import opmode_pkg::*;
#(
  parameter int unsigned N_PORTS = 2
) (
  input  logic [2:0]              mode_i,
  output logic [N_PORTS-1:0][1:0] fn_o
);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign fn_o[p] = port_fn(mode_i, p);
  end

endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  MODE_ADDR = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [2:0]        mode_o,
  output logic [1:0]        port_a_fn_o,
  output logic [1:0]        port_b_fn_o,
  output logic              dbg_enabled_o,
  output logic              dbg_active_o
);

  localparam int unsigned N_PORTS = 2;

  logic [REG_W-1:0] mode_q, mode_nxt, rst_image;
  logic             armed_q, armed_nxt, once_q, once_nxt;
  logic             dbg_en_d, dbg_act_d, dbg_en_q, dbg_act_q;
  logic             addr_hit, wr_hit;
  logic             ev_arm, ev_exit_special, ev_normal_switch, ev_reject;
  logic [N_PORTS-1:0][1:0] port_fn_w;

  assign addr_hit = (bus_addr_i == MODE_ADDR);
  assign wr_hit   = bus_wr_i && addr_hit;

  opmode_strap_decode u_strap (
    .strap_i   (strap_i),
    .image_o   (rst_image),
    .dbg_en_o  (dbg_en_d),
    .dbg_act_o (dbg_act_d)
  );

  opmode_write_guard u_guard (
    .cur_i              (mode_q),
    .armed_i            (armed_q),
    .once_i             (once_q),
    .wr_hit_i           (wr_hit),
    .wdata_i            (bus_wdata_i),
    .nxt_o              (mode_nxt),
    .nxt_armed_o        (armed_nxt),
    .nxt_once_o         (once_nxt),
    .ev_arm_o           (ev_arm),
    .ev_exit_special_o  (ev_exit_special),
    .ev_normal_switch_o (ev_normal_switch),
    .ev_reject_o        (ev_reject)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= rst_image;
      armed_q   <= 1'b0;
      once_q    <= 1'b0;
      dbg_en_q  <= dbg_en_d;
      dbg_act_q <= dbg_act_d;
    end else begin
      mode_q  <= mode_nxt;
      armed_q <= armed_nxt;
      once_q  <= once_nxt;
    end
  end

  opmode_port_map #(.N_PORTS(N_PORTS)) u_ports (
    .mode_i (mode_q[7:5]),
    .fn_o   (port_fn_w)
  );

  assign mode_o        = mode_q[7:5];
  assign port_a_fn_o   = port_fn_w[0];
  assign port_b_fn_o   = port_fn_w[1];
  assign dbg_enabled_o = dbg_en_q;
  assign dbg_active_o  = dbg_act_q;
  assign bus_rdata_o   = addr_hit ? mode_q : '0;

  AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[7:5] != 3'b110); // R9
  AST_BIT1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_o[1]); // R4
  AST_FREE_BITS_TAKE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((mode_q & FREE_MASK) == ($past(bus_wdata_i) & FREE_MASK))); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mode_q)); // R10
  AST_ARM_STAYS_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> !mode_q[7]); // R7
  AST_EXIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(mode_q[7])) |-> $past(armed_q)); // R7
  AST_EXIT_REACHES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit_special |=> mode_q[7]); // R7
  AST_NORMAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_q[7])) |-> mode_q[7]); // R9
  AST_SWITCH_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_normal_switch |=> once_q); // R8
  AST_ONCE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[7] && once_q) |=> $stable(mode_q[7:5])); // R8
  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> $stable(mode_q[7:5])); // R9
  AST_DBG_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active_o |-> dbg_enabled_o); // R3

endmodule

// File: tb/opmode_ctrl_bench.sv
`timescale 1ns/1ps
module opmode_ctrl_bench;

  localparam logic [7:0] MADDR = 8'h0B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap = 3'b000;
  logic [7:0] bus_addr = MADDR;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] mode;
  logic [1:0] pa, pb;
  logic       den, dact;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_reg;
  logic       m_arm, m_once, m_dbg;

  always #2.5 clk = ~clk;

  opmode_ctrl u_opmode_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_i(strap),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(rdata), .mode_o(mode), .port_a_fn_o(pa), .port_b_fn_o(pb),
    .dbg_enabled_o(den), .dbg_active_o(dact)
  );

  function automatic logic [7:0] exp_image(input logic [2:0] s);
    case (s)
      3'b000: return 8'h19;
      3'b001: return 8'h39;
      3'b010: return 8'h59;
      3'b011: return 8'h79;
      3'b100: return 8'h90;
      3'b101: return 8'hB0;
      3'b110: return 8'h59;
      default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [3:0] exp_ports(input logic [2:0] md);
    if (md[1:0] == 2'b00) return 4'h0;
    if (md[1:0] == 2'b01) return {2'd2, 2'd1};
    return {2'd2, 2'd2};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    logic [3:0] ep;
    ep = exp_ports(m_reg[7:5]);
    chk({tag, " rdata"}, rdata, m_reg);
    chk({tag, " R2 mode"}, {5'd0, mode}, {5'd0, m_reg[7:5]});
    chk({tag, " R2 ports"}, {4'd0, pa, pb}, {4'd0, ep});
    chk({tag, " R3 dbg"}, {6'd0, den, dact}, {6'd0, m_dbg, m_dbg});
  endtask

  task automatic model_write(input logic [7:0] d);
    m_reg = (m_reg & 8'hE2) | (d & 8'h1D);
    if (!m_reg[7]) begin
      if (!d[7]) begin
        m_reg[6:5] = d[6:5];
        m_arm = 0;
      end else if (!m_arm) begin
        m_arm = 1;
      end else if (d[6:5] != 2'b10) begin
        m_reg[7:5] = d[7:5];
        m_arm = 0;
      end
    end else if (d[7] && d[6:5] != 2'b10 && d[6:5] != m_reg[6:5] && !m_once) begin
      m_reg[6:5] = d[6:5];
      m_once = 1;
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 0; strap = s; bus_wr = 0; bus_addr = MADDR;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reg = exp_image(s); m_arm = 0; m_once = 0; m_dbg = (s == 3'b000);
    #1;
  endtask

  task automatic do_bus(input logic [7:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = we; bus_wdata = d;
    if (we && a == MADDR) model_write(d);
    @(negedge clk);
    bus_wr = 0; bus_addr = MADDR;
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 R2 R3: every strap value
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      chk("R1 reset image", rdata, exp_image(3'(s)));
      chk_all("R1");
    end
    // R4: other address reads zero
    @(negedge clk); bus_addr = 8'h0C; #1;
    chk("R4 other addr", rdata, 8'h00);
    bus_addr = MADDR;
    // R6: special rewrites
    do_reset(3'b011);
    do_bus(MADDR, 1, 8'h20); chk_all("R6 to narrow");
    do_bus(MADDR, 1, 8'h40); chk_all("R6 to periph");
    do_bus(MADDR, 1, 8'h1F); chk_all("R6 to single");
    chk("R6 value", rdata, 8'h1D);
    // R7: double write exit
    do_reset(3'b000);
    do_bus(MADDR, 1, 8'hB0); chk("R7 first ignored", {5'd0, mode}, 8'h00);
    do_bus(MADDR, 1, 8'hB0); chk("R7 second exits", {5'd0, mode}, 8'h05);
    chk_all("R7");
    do_reset(3'b001);
    do_bus(MADDR, 1, 8'hF0); do_bus(MADDR, 1, 8'h30); do_bus(MADDR, 1, 8'hF0);
    chk("R7 disarmed", {5'd0, mode}, 8'h01);
    do_bus(MADDR, 1, 8'hD0); chk("R7 reserved second", {5'd0, mode}, 8'h01);
    do_bus(MADDR, 1, 8'hF0); chk("R7 still armed", {5'd0, mode}, 8'h07);
    do_reset(3'b000);
    do_bus(MADDR, 1, 8'h90);
    do_reset(3'b000);
    do_bus(MADDR, 1, 8'h90); chk("R7 reset disarms", {5'd0, mode}, 8'h00);
    // R8: single normal switch
    do_reset(3'b100);
    do_bus(MADDR, 1, 8'h90); chk_all("R8 same mode");
    do_bus(MADDR, 1, 8'hF0); chk("R8 first switch", {5'd0, mode}, 8'h07);
    do_bus(MADDR, 1, 8'hB0); chk("R8 second ignored", {5'd0, mode}, 8'h07);
    // R9 with R5: rejected mode, free bits updated
    do_reset(3'b101);
    do_bus(MADDR, 1, 8'h1D); chk("R9 R5 special req", rdata, 8'hBD);
    do_bus(MADDR, 1, 8'hC4); chk("R9 R5 reserved req", rdata, 8'hA4);
    // R10: no strobe, wrong address
    do_bus(MADDR, 0, 8'hFF); chk("R10 no strobe", rdata, 8'hA4);
    do_bus(8'h0A, 1, 8'hFF); chk("R10 wrong addr", rdata, 8'hA4);
    // random mix
    for (int i = 0; i < 600; i++) begin
      automatic int unsigned r = $urandom % 100;
      automatic logic [7:0] d = 8'($urandom);
      if (r < 4) begin
        do_reset(3'($urandom));
        chk_all("R1 rand");
      end else if (r < 16) begin
        do_bus((r[0] ? 8'($urandom) | 8'h80 : MADDR), r[0], d);
        chk_all("R10 rand");
      end else begin
        do_bus(MADDR, 1, d);
        chk_all(m_reg[7] ? "R8 R9 R5 rand" : "R6 R7 R5 rand");
      end
    end
    finish_run();
  end

endmodule